// File: doc/BRIEF.md
# Noisy-Response Key Rebuilder

This block turns a noisy physical fingerprint back into a fixed secret key. At enrollment, off-chip, a random codeword is chosen and XORed with the clean response to form a mask. That mask is stored next to the chip together with a small index that picks a hash function. On the chip, the noisy response and the stored mask stream in one bit per cycle. Each group of bits is XORed with the mask and decoded by majority vote. The decoded codeword bit is XORed back onto the mask to rebuild the enrolled response. The rebuilt response is then folded into a key through a Toeplitz-matrix multiply over GF(2), seeded by the stored index.

The response is cut into `CWS` codewords. Each codeword holds `GRPS` groups of `REP` repeated bits, and every codeword is decoded on its own, group by group. A run opens with a `start` pulse, which also captures the hash index. The run ends with a one-cycle `done` pulse. A group whose vote is split evenly makes the run report a failure and give out an all-zero key.

Top module: `fxr_key_rebuild`

## Requirements
- R1: After reset, `key` is all zero and `done` and `fail` are low.
- R2: Bits are grouped by arrival order, `REP` (default 4) to a group. There are `GRPS*CWS` groups, 96 bits in total by default. For each group, x = resp XOR help. The decoded bit is 1 when more than `REP/2` bits of x are 1. The rebuilt bits are help XOR the decoded bit. So one flipped bit per group still yields the enrolled response, and three or four flips complement that group.
- R3: Column bit i starts as `hidx[i mod IDX_W]`. For each rebuilt bit j in arrival order, the key accumulator is XORed with the column when the bit is 1. The column then shifts up by one place, and its new bit 0 is the old top bit XOR the old bit 0.
- R4: `hidx` is captured only by a `start` accepted while idle. A `start` during a run is ignored.
- R5: When any group's vote is an exact tie, `fail` is 1 at `done` and `key` is all zero.
- R6: `done` is high for exactly one cycle. It rises `REP+1` clock edges after the edge that accepts the final response bit.
- R7: `in_valid` is ignored outside a run. Within a run, gaps in `in_valid` are allowed, and only cycles with `in_valid` high supply bits. Bits beyond the total are ignored.
- R8: `key` and `fail` hold their values after `done` until the next accepted `start`, which clears both to zero by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a run when idle |
| hidx | input | IDX_W | Hash-family index, captured at start |
| in_valid | input | 1 | A response/mask bit pair is present |
| resp_bit | input | 1 | Noisy response bit |
| help_bit | input | 1 | Stored mask bit |
| key | output | KEY_W | Rebuilt key, zero on failure |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A tied vote occurred in the last run |

## Verification
Properties check a fixed set of behaviours on every cycle. `done` is a single-cycle pulse and only comes after the bit shifter has drained. Groups never arrive fast enough to overrun the shifter. A failed run never shows a non-zero key. While idle, both the bit count and the held key stay frozen. Key values depend on the error pattern and on the index, so only the bench's runs can show them. These runs sweep each group through clean, single-flip, tied and overwhelmed patterns, and compare the result with a Toeplitz product the bench computes itself. The bench also covers the `done` timing under input gaps and a `start` pulse arriving mid-run.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int unsigned FXR_KEY_W = 128;
    localparam int unsigned FXR_IDX_W = 32;
    localparam int unsigned FXR_REP   = 4;
    localparam int unsigned FXR_GRPS  = 8;
    localparam int unsigned FXR_CWS   = 3;

    typedef enum logic [1:0] {
        FXR_IDLE  = 2'd0,
        FXR_RUN   = 2'd1,
        FXR_DRAIN = 2'd2
    } fxr_state_e;

    typedef struct packed {
        logic dec;
        logic tie;
    } fxr_vote_t;

    // Majority decision over a group of rep bits that holds `ones` set bits.
    function automatic fxr_vote_t fxr_vote(input int unsigned ones, input int unsigned rep);
        fxr_vote_t v;
        v.tie = ((2 * ones) == rep);
        v.dec = ((2 * ones) > rep);
        return v;
    endfunction

endpackage

// File: rtl/fxr_rep_decoder.sv
module fxr_rep_decoder
    import fxr_pkg::*;
#(
    parameter int unsigned REP = FXR_REP
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           bit_valid,
    input  logic           resp_bit,
    input  logic           help_bit,
    output logic           grp_valid,
    output logic [REP-1:0] grp_bits,
    output logic           grp_tie
);
    localparam int unsigned PW = (REP > 1) ? $clog2(REP) : 1;
    localparam int unsigned CW = $clog2(REP + 1);

    logic [PW-1:0]  pos_q;
    logic [CW-1:0]  ones_q, ones_n;
    logic [REP-1:0] hbuf_q, hbuf_n;
    logic           last_bit;
    fxr_vote_t      vote;

    always_comb begin
        hbuf_n         = hbuf_q;
        hbuf_n[pos_q]  = help_bit;
        ones_n         = ones_q + CW'(resp_bit ^ help_bit);
        last_bit       = (pos_q == PW'(REP - 1));
        vote           = fxr_vote(32'(ones_n), REP);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q     <= '0;
            ones_q    <= '0;
            hbuf_q    <= '0;
            grp_valid <= 1'b0;
            grp_bits  <= '0;
            grp_tie   <= 1'b0;
        end else begin
            grp_valid <= 1'b0;
            if (bit_valid) begin
                if (last_bit) begin
                    grp_valid <= 1'b1;
                    grp_bits  <= hbuf_n ^ {REP{vote.dec}};
                    grp_tie   <= vote.tie;
                    pos_q     <= '0;
                    ones_q    <= '0;
                    hbuf_q    <= '0;
                end else begin
                    pos_q  <= pos_q + PW'(1);
                    ones_q <= ones_n;
                    hbuf_q <= hbuf_n;
                end
            end
        end
    end

    // R2: a group needs REP input bits, so results never come back to back.
    p_group_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        grp_valid |=> !grp_valid);

endmodule

// File: rtl/fxr_serializer.sv
module fxr_serializer
    import fxr_pkg::*;
#(
    parameter int unsigned REP = FXR_REP
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       load,
    input  logic [REP-1:0]             load_bits,
    output logic                       head_valid,
    output logic                       head_bit,
    output logic [$clog2(REP+1)-1:0]   level
);
    localparam int unsigned LW = $clog2(REP + 1);

    logic [REP-1:0] sh_q;
    logic [LW-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_bits;
            cnt_q <= LW'(REP);
        end else if (cnt_q != '0) begin
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - LW'(1);
        end
    end

    assign head_valid = (cnt_q != '0);
    assign head_bit   = sh_q[0];
    assign level      = cnt_q;

    // R2: a new group arrives only when at most the last old bit remains.
    p_no_overrun_r2: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q <= LW'(1)));

endmodule

// File: rtl/fxr_toeplitz_hash.sv
module fxr_toeplitz_hash
    import fxr_pkg::*;
#(
    parameter int unsigned KEY_W = FXR_KEY_W,
    parameter int unsigned IDX_W = FXR_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [IDX_W-1:0] idx,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [KEY_W-1:0] acc_nxt
);
    logic [KEY_W-1:0] col_q, col_seed, col_step, acc_q;

    for (genvar i = 0; i < KEY_W; i++) begin : g_seed
        assign col_seed[i] = idx[i % IDX_W];
    end

    always_comb begin
        col_step = {col_q[KEY_W-2:0], col_q[KEY_W-1] ^ col_q[0]};
        acc_nxt  = (bit_en && bit_in) ? (acc_q ^ col_q) : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            acc_q <= '0;
        end else if (init) begin
            col_q <= col_seed;
            acc_q <= '0;
        end else if (bit_en) begin
            col_q <= col_step;
            acc_q <= acc_nxt;
        end
    end

    // R3: a fresh run starts folding from an empty accumulator.
    p_init_clears_r3: assert property (@(posedge clk) disable iff (rst)
        init |=> (acc_q == '0));

endmodule

// File: rtl/fxr_key_rebuild.sv
module fxr_key_rebuild
    import fxr_pkg::*;
#(
    parameter int unsigned KEY_W = FXR_KEY_W,
    parameter int unsigned IDX_W = FXR_IDX_W,
    parameter int unsigned REP   = FXR_REP,
    parameter int unsigned GRPS  = FXR_GRPS,
    parameter int unsigned CWS   = FXR_CWS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] hidx,
    input  logic             in_valid,
    input  logic             resp_bit,
    input  logic             help_bit,
    output logic [KEY_W-1:0] key,
    output logic             done,
    output logic             fail
);
    localparam int unsigned TOTAL = REP * GRPS * CWS;
    localparam int unsigned BW    = $clog2(TOTAL + 1);
    localparam int unsigned GW    = (GRPS > 1) ? $clog2(GRPS) : 1;
    localparam int unsigned CWW   = (CWS > 1) ? $clog2(CWS) : 1;
    localparam int unsigned SW    = $clog2(REP + 1);

    fxr_state_e       state_q;
    logic [BW-1:0]    bits_q;
    logic [GW-1:0]    grp_q;
    logic [CWW-1:0]   cw_q;
    logic             fail_seen_q;
    logic [KEY_W-1:0] key_q;
    logic             done_q, fail_q;

    logic             start_go, take, last_grp, finish;
    logic             grp_valid, grp_tie;
    logic [REP-1:0]   grp_bits;
    logic             head_valid, head_bit;
    logic [SW-1:0]    ser_level;
    logic [KEY_W-1:0] acc_nxt;

    assign start_go = start && (state_q == FXR_IDLE);
    assign take     = in_valid && (state_q == FXR_RUN) && (bits_q != BW'(TOTAL));
    assign last_grp = grp_valid && (grp_q == GW'(GRPS - 1)) && (cw_q == CWW'(CWS - 1));
    assign finish   = (state_q == FXR_DRAIN) && (ser_level == SW'(1));

    fxr_rep_decoder #(.REP(REP)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_go),
        .bit_valid (take),
        .resp_bit  (resp_bit),
        .help_bit  (help_bit),
        .grp_valid (grp_valid),
        .grp_bits  (grp_bits),
        .grp_tie   (grp_tie)
    );

    fxr_serializer #(.REP(REP)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .clr        (start_go),
        .load       (grp_valid),
        .load_bits  (grp_bits),
        .head_valid (head_valid),
        .head_bit   (head_bit),
        .level      (ser_level)
    );

    fxr_toeplitz_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
        .clk     (clk),
        .rst     (rst),
        .init    (start_go),
        .idx     (hidx),
        .bit_en  (head_valid),
        .bit_in  (head_bit),
        .acc_nxt (acc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FXR_IDLE;
            bits_q      <= '0;
            grp_q       <= '0;
            cw_q        <= '0;
            fail_seen_q <= 1'b0;
            key_q       <= '0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                FXR_IDLE: begin
                    if (start) begin
                        state_q     <= FXR_RUN;
                        bits_q      <= '0;
                        grp_q       <= '0;
                        cw_q        <= '0;
                        fail_seen_q <= 1'b0;
                        key_q       <= '0;
                        fail_q      <= 1'b0;
                    end
                end
                FXR_RUN: begin
                    if (take) begin
                        bits_q <= bits_q + BW'(1);
                    end
                    if (grp_valid) begin
                        fail_seen_q <= fail_seen_q | grp_tie;
                        if (grp_q == GW'(GRPS - 1)) begin
                            grp_q <= '0;
                            cw_q  <= cw_q + CWW'(1);
                        end else begin
                            grp_q <= grp_q + GW'(1);
                        end
                        if (last_grp) begin
                            state_q <= FXR_DRAIN;
                        end
                    end
                end
                FXR_DRAIN: begin
                    if (finish) begin
                        done_q  <= 1'b1;
                        fail_q  <= fail_seen_q;
                        key_q   <= fail_seen_q ? '0 : acc_nxt;
                        state_q <= FXR_IDLE;
                    end
                end
                default: state_q <= FXR_IDLE;
            endcase
        end
    end

    assign key  = key_q;
    assign done = done_q;
    assign fail = fail_q;

    // R6: done lasts a single cycle.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6: done appears only once every rebuilt bit has left the shifter.
    p_done_drained_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ser_level == '0) && (state_q == FXR_IDLE));

    // R5: a failed run never exposes key material.
    p_fail_zero_key_r5: assert property (@(posedge clk) disable iff (rst)
        fail_q |-> (key_q == '0));

    // R7: while idle, arriving bits do not advance the bit count.
    p_idle_ignores_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == FXR_IDLE) && !start |=> $stable(bits_q));

    // R8: results stay put while idle with no start.
    p_hold_result_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == FXR_IDLE) && !start |=> $stable(key_q) && $stable(fail_q));

endmodule

// File: tb/fxr_key_rebuild_tb_top.sv
module fxr_key_rebuild_tb_top;
    localparam int KW  = 128;
    localparam int IW  = 32;
    localparam int REP = 4;
    localparam int GR  = 8;
    localparam int CW  = 3;
    localparam int NG  = GR * CW;
    localparam int TOT = REP * NG;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [IW-1:0] hidx;
    logic          in_valid, resp_bit, help_bit;
    logic [KW-1:0] key;
    logic          done, fail;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fxr_key_rebuild #(.KEY_W(KW), .IDX_W(IW), .REP(REP), .GRPS(GR), .CWS(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .hidx(hidx), .in_valid(in_valid),
        .resp_bit(resp_bit), .help_bit(help_bit), .key(key), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string what, input logic [KW-1:0] got, input logic [KW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h", what, got, exp);
        end
    endtask

    // Toeplitz product from R3.
    function automatic logic [KW-1:0] ref_hash(input logic [IW-1:0] idx, input logic [TOT-1:0] rec);
        logic [KW-1:0] col, acc;
        for (int i = 0; i < KW; i++) col[i] = idx[i % IW];
        acc = '0;
        for (int j = 0; j < TOT; j++) begin
            if (rec[j]) acc ^= col;
            col = {col[KW-2:0], col[KW-1] ^ col[0]};
        end
        return acc;
    endfunction

    // Majority rebuild from R2, tie detection from R5.
    function automatic logic [TOT-1:0] ref_recover(input logic [TOT-1:0] rsp, input logic [TOT-1:0] hlp,
                                                   output logic tie);
        logic [TOT-1:0] rec;
        tie = 1'b0;
        for (int g = 0; g < NG; g++) begin
            int ones;
            ones = 0;
            for (int k = 0; k < REP; k++) ones += int'(rsp[g*REP+k] ^ hlp[g*REP+k]);
            if (2 * ones == REP) tie = 1'b1;
            for (int k = 0; k < REP; k++) rec[g*REP+k] = hlp[g*REP+k] ^ (2 * ones > REP);
        end
        return rec;
    endfunction

    task automatic make_case(output logic [TOT-1:0] enr, output logic [TOT-1:0] hlp);
        enr = {$urandom, $urandom, $urandom};
        for (int g = 0; g < NG; g++) begin
            logic m;
            m = logic'($urandom % 2);
            for (int k = 0; k < REP; k++) hlp[g*REP+k] = enr[g*REP+k] ^ m;
        end
    endtask

    // mode: 0 model, 1 expect key = hash of enrolled response (R2)
    task automatic run_case(input logic [IW-1:0] idx, input logic [TOT-1:0] err, input bit gaps,
                            input bit poke_busy, input bit direct, input string tag);
        logic [TOT-1:0] enr, hlp, noisy, rec;
        logic [KW-1:0]  exp_key;
        logic           tie;
        make_case(enr, hlp);
        noisy = enr ^ err;
        rec = ref_recover(noisy, hlp, tie);
        exp_key = tie ? '0 : (direct ? ref_hash(idx, enr) : ref_hash(idx, rec));
        @(negedge clk);
        start = 1'b1; hidx = idx;
        @(negedge clk);
        start = 1'b0; hidx = ~idx;
        for (int j = 0; j < TOT; j++) begin
            if (gaps && (j % 5 == 2)) begin
                in_valid = 1'b0; resp_bit = 1'b1; help_bit = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; resp_bit = noisy[j]; help_bit = hlp[j];
            if (poke_busy && j == TOT / 2) begin
                start = 1'b1; hidx = idx ^ 32'h5a5a_0f0f;
            end
            @(negedge clk);
            start = 1'b0;
        end
        in_valid = 1'b0;
        repeat (REP) @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done early"}, KW'(done), '0);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R6 done at REP+1"}, KW'(done), KW'(1));
        chk(fail == tie, {tag, " R5 fail flag"}, KW'(fail), KW'(tie));
        chk(key == exp_key, {tag, tie ? " R5 zero key" : " R3 key value"}, key, exp_key);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 single pulse"}, KW'(done), '0);
        chk(key == exp_key, {tag, " R8 key held"}, key, exp_key);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] nt [10];
        logic [3:0] tp [6];
        logic [TOT-1:0] err;
        logic [KW-1:0]  held;
        nt = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h7, 4'hB, 4'hD, 4'hE, 4'hF};
        tp = '{4'h3, 4'h5, 4'h6, 4'h9, 4'hA, 4'hC};
        rst = 1'b1; start = 1'b0; hidx = '0; in_valid = 1'b0; resp_bit = 1'b0; help_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(key == '0, "R1 key after reset", key, '0);
        chk(done == 1'b0, "R1 done after reset", KW'(done), '0);
        chk(fail == 1'b0, "R1 fail after reset", KW'(fail), '0);

        // R2: sweep every non-tied group pattern across all groups
        for (int s = 0; s < 10; s++) begin
            for (int g = 0; g < NG; g++) err[g*REP +: REP] = nt[(g + s) % 10];
            run_case($urandom, err, s[0], 1'b0, 1'b0, "R2 sweep");
        end

        // R2: at most one flip per group rebuilds the enrolled response
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < NG; g++) err[g*REP +: REP] = nt[(g * 3 + s) % 5];
            run_case($urandom, err, s[1], 1'b0, 1'b1, "R2 corrected");
        end

        // R5: one tied group anywhere forces failure
        for (int t = 0; t < 6; t++) begin
            for (int g = 0; g < NG; g++) err[g*REP +: REP] = nt[g % 5];
            err[(t * 4 + 1) * REP +: REP] = tp[t];
            run_case($urandom, err, t[0], 1'b0, 1'b0, "R5 tie");
        end

        // R3: index corners
        run_case('0, '0, 1'b0, 1'b0, 1'b1, "R3 zero index");
        run_case('1, '0, 1'b0, 1'b0, 1'b1, "R3 ones index");

        // R4: start mid-run ignored, original index kept
        run_case(32'hC0DE_1234, '0, 1'b0, 1'b1, 1'b1, "R4 busy start");

        // R7: bits offered while idle are ignored
        for (int j = 0; j < 11; j++) begin
            in_valid = 1'b1; resp_bit = j[0]; help_bit = j[1];
            @(negedge clk);
        end
        in_valid = 1'b0;
        run_case(32'h0BAD_F00D, '0, 1'b1, 1'b0, 1'b1, "R7 idle noise");

        // R8: hold, then clear on start
        held = key;
        repeat (7) @(negedge clk);
        chk(key == held, "R8 key held while idle", key, held);
        start = 1'b1; hidx = 32'h1;
        @(negedge clk);
        start = 1'b0;
        chk(key == '0, "R8 key cleared by start", key, '0);
        chk(fail == 1'b0, "R8 fail cleared by start", KW'(fail), '0);
        for (int j = 0; j < TOT; j++) begin
            in_valid = 1'b1; resp_bit = 1'b0; help_bit = 1'b0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (REP + 3) @(negedge clk);
        chk(key == '0, "R3 all-zero response gives zero key", key, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule